// File: doc/BRIEF.md
# Cartridge Bus Glue with Open-Bus Latch

This block is the address-decode and read-return glue for an 8-bit, 6502-style cartridge bus. From the upper address bits and the phase clock M2 it makes the active-low chip-enable for an external ROM and a select for an on-chip ROM. An active-low strap picks one of two decode maps. With the strap low, the on-chip ROM owns the top 8 KiB and the external ROM is enabled one window lower. With the strap high, the on-chip ROM is switched off and the external enable covers the top window. That enable is the NAND of the three highest address bits, qualified by M2.

The block also returns read data for three partly populated status registers. Populated bits come straight from their source inputs. Every other bit, and every read of an address that no register claims, returns a held "open bus" byte. That byte reloads from the external data bus only on a fresh M2 high phase: M2 must have been low and then gone high again. Bus pin changes while M2 stays high do not reach it.

M2 and all other inputs are taken as synchronous to `clk`. Every output is registered. An output seen after edge k reflects the inputs sampled at edge k. The open-bus byte it uses is the one held before that edge.

Top module: `cart_bus_glue`

## Requirements
- R1: While `rst` is sampled high, the next outputs are `rom_ce_n`=1, `irom_sel`=0 and `rd_data`=0x00, and the open-bus byte and remembered M2 level both clear to 0.
- R2: With `irom_en_n`=0, `irom_sel` is 1 after an edge where `m2`=1 and `addr`[15:13]=3'b111, and 0 after any other edge.
- R3: With `irom_en_n`=0, `rom_ce_n` is 0 after an edge where `m2`=1 and `addr`[15:13]=3'b110, and 1 otherwise. The 0xE000–0xFFFF window does not assert it.
- R4: With `irom_en_n`=1, `irom_sel` stays 0. `rom_ce_n` is 0 exactly after edges where `m2`=1 and `addr`[15:13]=3'b111.
- R5: After an edge where `m2`=0, `rom_ce_n`=1 and `irom_sel`=0 whatever the address and strap.
- R6: On a read (`rw`=1) of a register, the populated bits of `rd_data` equal the source bits sampled at the same edge. Slot 0 is 0x40D3 with mask 0x81 and `src_bits`[7:0]. Slot 1 is 0x40D5 with mask 0x3F and `src_bits`[15:8]. Slot 2 is 0x40D6 with mask 0xC0 and `src_bits`[23:16].
- R7: On such a register read, the bits outside the mask equal the open-bus byte held before that edge.
- R8: The open-bus byte loads `bus_in` at an edge where `m2`=1 and the previous sampled `m2` was 0, and holds at every other edge. This holds even while `bus_in` changes with `m2` high.
- R9: A write cycle (`rw`=0), or a read of any address other than the three registers, gives `rd_data` equal to the full open-bus byte held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | CPU address |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| m2 | input | 1 | Phase clock M2, sampled on `clk` |
| irom_en_n | input | 1 | Strap: 0 enables the on-chip ROM decode |
| bus_in | input | 8 | External data bus value |
| src_bits | input | 24 | Status sources, 8 bits per register slot |
| rom_ce_n | output | 1 | External ROM chip-enable, active low |
| irom_sel | output | 1 | On-chip ROM select |
| rd_data | output | 8 | Read data returned for the current address |

## Verification
A wrong held open-bus byte stays hidden until a read misses every register. It then shows on all eight `rd_data` bits one cycle after that read is sampled. On a register read it shows only on the unpopulated bits. A bad remembered M2 level shows as a load that comes one M2 phase too early or too late. That is caught on the next unclaimed read, which the bench issues nearly every few cycles. A decode fault shows on `rom_ce_n` or `irom_sel` one edge after the offending address. The bench sweeps both straps and both M2 levels to expose it.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int NREG   = 3;
  // Register slots, slot 0 in the low bits
  localparam logic [NREG*ADDR_W-1:0] REG_ADDRS = {16'h40D6, 16'h40D5, 16'h40D3};
  localparam logic [NREG*DATA_W-1:0] REG_MASKS = {8'hC0, 8'h3F, 8'h81};
  // Top three address bits of the two ROM windows
  localparam logic [2:0] WIN_LOW  = 3'b110;
  localparam logic [2:0] WIN_HIGH = 3'b111;
endpackage

// File: rtl/cbg_window_dec.sv
module cbg_window_dec #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              m2,
  input  logic              irom_en_n,
  output logic              ce_n_d,
  output logic              irom_d
);
  import cbg_pkg::*;
  logic [2:0] top3;
  logic in_low, in_high;

  assign top3    = addr[ADDR_W-1 -: 3];
  assign in_low  = (top3 == WIN_LOW);
  assign in_high = (top3 == WIN_HIGH);

  always_comb begin
    if (irom_en_n) begin
      ce_n_d = !(m2 && in_high);
      irom_d = 1'b0;
    end else begin
      ce_n_d = !(m2 && in_low);
      irom_d = m2 && in_high;
    end
  end
endmodule

// File: rtl/cbg_openbus.sv
module cbg_openbus #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m2,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] ob_q,
  output logic              m2_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ob_q <= '0;
      m2_q <= 1'b0;
    end else begin
      m2_q <= m2;
      if (m2 && !m2_q) ob_q <= bus_in;
    end
  end
endmodule

// File: rtl/cbg_reg_merge.sv
module cbg_reg_merge #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NREG   = 3,
  parameter logic [NREG*ADDR_W-1:0] ADDRS = '0,
  parameter logic [NREG*DATA_W-1:0] MASKS = '0
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   rw,
  input  logic [NREG*DATA_W-1:0] src_bits,
  input  logic [DATA_W-1:0]      ob,
  output logic [DATA_W-1:0]      rd_d
);
  logic [NREG-1:0]             hit;
  logic [NREG-1:0][DATA_W-1:0] merged;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam logic [DATA_W-1:0] MSK = MASKS[i*DATA_W +: DATA_W];
    assign hit[i]    = rw && (addr == ADDRS[i*ADDR_W +: ADDR_W]);
    assign merged[i] = (src_bits[i*DATA_W +: DATA_W] & MSK) | (ob & ~MSK);
  end

  always_comb begin
    rd_d = ob;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_d = merged[i];
  end
endmodule

// File: rtl/cart_bus_glue.sv
module cart_bus_glue #(
  parameter int ADDR_W = cbg_pkg::ADDR_W,
  parameter int DATA_W = cbg_pkg::DATA_W,
  parameter int NREG   = cbg_pkg::NREG
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   rw,
  input  logic                   m2,
  input  logic                   irom_en_n,
  input  logic [DATA_W-1:0]      bus_in,
  input  logic [NREG*DATA_W-1:0] src_bits,
  output logic                   rom_ce_n,
  output logic                   irom_sel,
  output logic [DATA_W-1:0]      rd_data
);
  logic              ce_n_d, irom_d;
  logic [DATA_W-1:0] ob_q, rd_d;
  logic              m2_q;

  cbg_window_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .m2(m2), .irom_en_n(irom_en_n),
    .ce_n_d(ce_n_d), .irom_d(irom_d)
  );

  cbg_openbus #(.DATA_W(DATA_W)) u_ob (
    .clk(clk), .rst(rst), .m2(m2), .bus_in(bus_in),
    .ob_q(ob_q), .m2_q(m2_q)
  );

  cbg_reg_merge #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG),
    .ADDRS(cbg_pkg::REG_ADDRS[NREG*ADDR_W-1:0]),
    .MASKS(cbg_pkg::REG_MASKS[NREG*DATA_W-1:0])
  ) u_merge (
    .addr(addr), .rw(rw), .src_bits(src_bits), .ob(ob_q), .rd_d(rd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_ce_n <= 1'b1;
      irom_sel <= 1'b0;
      rd_data  <= '0;
    end else begin
      rom_ce_n <= ce_n_d;
      irom_sel <= irom_d;
      rd_data  <= rd_d;
    end
  end
endmodule

// File: rtl/cart_bus_glue_chk.sv
module cart_bus_glue_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] addr,
  input logic        rw,
  input logic        m2,
  input logic        irom_en_n,
  input logic [23:0] src_bits,
  input logic        rom_ce_n,
  input logic        irom_sel,
  input logic [7:0]  rd_data,
  input logic [7:0]  ob_q,
  input logic        m2_q
);
  logic any_hit;
  assign any_hit = rw && (addr == 16'h40D3 || addr == 16'h40D5 || addr == 16'h40D6);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (rom_ce_n && !irom_sel && rd_data == 8'h00)); // R1
  AST_IROM_HIGH_WIN: assert property (@(posedge clk) disable iff (rst)
    (m2 && !irom_en_n && addr[15:13] == 3'b111) |=> irom_sel); // R2
  AST_CE_LOW_WIN: assert property (@(posedge clk) disable iff (rst)
    (m2 && !irom_en_n && addr[15:13] == 3'b110) |=> !rom_ce_n); // R3
  AST_STRAP_NO_IROM: assert property (@(posedge clk) disable iff (rst)
    irom_en_n |=> !irom_sel); // R4
  AST_M2_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !m2 |=> (rom_ce_n && !irom_sel)); // R5
  AST_SLOT0_LIVE: assert property (@(posedge clk) disable iff (rst)
    (rw && addr == 16'h40D3) |=> ((rd_data & 8'h81) == ($past(src_bits[7:0]) & 8'h81))); // R6
  AST_SLOT0_OPEN: assert property (@(posedge clk) disable iff (rst)
    (rw && addr == 16'h40D3) |=> ((rd_data & 8'h7E) == ($past(ob_q) & 8'h7E))); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(m2 && !m2_q) |=> $stable(ob_q)); // R8
  AST_MISS_OPEN: assert property (@(posedge clk) disable iff (rst)
    !any_hit |=> (rd_data == $past(ob_q))); // R9
endmodule

bind cart_bus_glue cart_bus_glue_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rw(rw), .m2(m2), .irom_en_n(irom_en_n),
  .src_bits(src_bits), .rom_ce_n(rom_ce_n), .irom_sel(irom_sel),
  .rd_data(rd_data), .ob_q(ob_q), .m2_q(m2_q)
);

// File: tb/cart_bus_glue_tb.sv
`timescale 1ns/1ps
module cart_bus_glue_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr;
  logic        rw, m2, irom_en_n;
  logic [7:0]  bus_in;
  logic [23:0] src_bits;
  logic        rom_ce_n, irom_sel;
  logic [7:0]  rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // expected values and bench model state
  logic       e_ce_n, e_irom;
  logic [7:0] e_rd;
  string      t_ce, t_irom, t_rd, tag_over;
  bit         pending = 0;
  logic [7:0] m_ob = 8'h00;
  logic       m_m2p = 1'b0;

  always #2.5 clk = ~clk;

  cart_bus_glue u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rw(rw), .m2(m2), .irom_en_n(irom_en_n),
    .bus_in(bus_in), .src_bits(src_bits),
    .rom_ce_n(rom_ce_n), .irom_sel(irom_sel), .rd_data(rd_data)
  );

  function automatic logic [7:0] mask_of(input int s);
    return (s == 0) ? 8'h81 : (s == 1) ? 8'h3F : 8'hC0;
  endfunction

  function automatic int slot_of(input logic [15:0] a, input logic r);
    if (!r) return -1;
    if (a == 16'h40D3) return 0;
    if (a == 16'h40D5) return 1;
    if (a == 16'h40D6) return 2;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_pending();
    if (pending) begin
      chk(t_ce,   {7'd0, rom_ce_n}, {7'd0, e_ce_n});
      chk(t_irom, {7'd0, irom_sel}, {7'd0, e_irom});
      chk(t_rd,   rd_data, e_rd);
    end
  endtask

  task automatic step(input logic r, input logic [15:0] a, input logic w_rw,
                      input logic w_m2, input logic strap, input logic [7:0] bus,
                      input logic [23:0] src);
    int s;
    logic [2:0] t3;
    @(negedge clk);
    check_pending();
    rst = r; addr = a; rw = w_rw; m2 = w_m2; irom_en_n = strap;
    bus_in = bus; src_bits = src;
    t3 = a[15:13];
    s = slot_of(a, w_rw);
    if (r) begin
      e_ce_n = 1'b1; e_irom = 1'b0; e_rd = 8'h00;
      t_ce = "R1 ce"; t_irom = "R1 irom"; t_rd = "R1 rd";
      m_ob = 8'h00; m_m2p = 1'b0;
    end else begin
      if (strap) begin
        e_ce_n = !(w_m2 && t3 == 3'b111); e_irom = 1'b0;
        t_ce = w_m2 ? "R4 ce" : "R5 ce"; t_irom = w_m2 ? "R4 irom" : "R5 irom";
      end else begin
        e_ce_n = !(w_m2 && t3 == 3'b110); e_irom = w_m2 && t3 == 3'b111;
        t_ce = w_m2 ? "R3 ce" : "R5 ce"; t_irom = w_m2 ? "R2 irom" : "R5 irom";
      end
      if (s >= 0) begin
        e_rd = (src[s*8 +: 8] & mask_of(s)) | (m_ob & ~mask_of(s));
        t_rd = "R6,R7 reg rd";
      end else begin
        e_rd = m_ob;
        t_rd = "R9 open rd";
      end
      if (tag_over != "") t_rd = tag_over;
      if (w_m2 && !m_m2p) m_ob = bus;
      m_m2p = w_m2;
    end
    pending = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'h1234_5678));
    tag_over = "";
    // R1: reset state
    step(1, 16'hE000, 1, 1, 0, 8'hFF, 24'hFFFFFF);
    step(1, 16'hC000, 1, 1, 0, 8'hFF, 24'hFFFFFF);
    // R2 / R3 directed, strap low
    step(0, 16'hE123, 1, 0, 0, 8'h5A, 24'h0);
    step(0, 16'hE123, 1, 1, 0, 8'h5A, 24'h0);   // loads 5A, irom=1
    step(0, 16'hC7FF, 1, 1, 0, 8'h11, 24'h0);   // ce low
    step(0, 16'hBFFF, 1, 1, 0, 8'h22, 24'h0);   // outside
    // R4 strap high
    step(0, 16'hFFFF, 1, 1, 1, 8'h33, 24'h0);
    step(0, 16'hDFFF, 1, 1, 1, 8'h33, 24'h0);
    // R8: bus changes with m2 held high do not load
    tag_over = "R8 hold";
    step(0, 16'h1234, 1, 1, 0, 8'hA5, 24'h0);
    step(0, 16'h1234, 1, 1, 0, 8'h3C, 24'h0);
    step(0, 16'h1234, 1, 0, 0, 8'h3C, 24'h0);
    step(0, 16'h1234, 1, 1, 0, 8'hC3, 24'h0);   // fresh high phase: load C3
    step(0, 16'h1234, 1, 1, 0, 8'h00, 24'h0);
    tag_over = "";
    // R6/R7 each slot, and write cycle to a register address (R9)
    step(0, 16'h40D3, 1, 1, 0, 8'h00, 24'hC0_3F_81);
    step(0, 16'h40D5, 1, 1, 0, 8'h00, 24'hFF_00_FF);
    step(0, 16'h40D6, 1, 1, 0, 8'h00, 24'h00_FF_00);
    step(0, 16'h40D6, 0, 1, 0, 8'h00, 24'hFF_FF_FF);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 5);
      case (k)
        0: a = 16'h40D3;
        1: a = 16'h40D5;
        2: a = 16'h40D6;
        3: a = {3'b110, 13'($urandom)};
        4: a = {3'b111, 13'($urandom)};
        default: a = 16'($urandom);
      endcase
      step((i == 2000), a, 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
           8'($urandom), 24'($urandom));
    end
    @(negedge clk);
    check_pending();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule